// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block is the programmable feedback divider of a frequency synthesizer loop. A fast input clock feeds a prescaler whose modulus is either 64 or 66. A swallow count A and a main count B choose how many prescaler cycles of each kind make up one output period. The total ratio is N = 2×(32×B + A), and the output gives a single one-cycle pulse once every N input cycles.

Software writes a 17-bit divide word with a load strobe. The divider checks the word and keeps it pending until the period that is running has finished, so no output period ever mixes two settings. A word that breaks the counting rules raises an error flag and is thrown away. Driving the enable low puts the divider in standby: every counter is cleared and the output stays low.

Top module: `pswallow_div`

## Requirements
- R1: `div_out` is high for exactly one input cycle once every N = 2×(32×B + A) input cycles. A is `word[4:0]` and B is `word[16:5]`.
- R2: Within each output period the prescaler first completes A cycles of 66 input clocks, then B−A cycles of 64 input clocks. A prescaler cycle of 64 never counts past 63.
- R3: A word is accepted when 3 ≤ B ≤ 4095 and A ≤ B. This includes the boundary words B=3 and A=B=31.
- R4: An accepted word takes effect from the first full output period after the period in which it was loaded. The period in progress keeps its old length.
- R5: A word with B < 3 or A > B sets `word_err` high from the cycle after the load. The flag stays high until the next load, and the divider keeps its previous ratio.
- R6: While `en` is low, `div_out` stays low and the counters are held cleared. After `en` rises, the first pulse appears after N enabled input cycles.
- R7: After a synchronous reset, `div_out` and `word_err` are low and the ratio is A=0, B=3, which gives N=192.
- R8: A word that is accepted during standby, at least one cycle before `en` rises, sets the ratio of the first period after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low selects standby |
| load | input | 1 | One-cycle strobe that captures `word` |
| word | input | 17 | Divide word: A in bits 4:0, B in bits 16:5 |
| div_out | output | 1 | Registered output pulse, one cycle per N input cycles |
| word_err | output | 1 | Registered flag: the last loaded word was rejected |

## Verification
`word_err` is registered on the load edge, so it is sampled on the falling edge that follows that rising edge. Each pulse interval is measured by counting rising edges from one falling-edge sample where `div_out` is high to the next one, and this count must equal N exactly. To check that a load cannot shorten the current period, the bench includes the cycles spent before and during the load in the count for that interval, then measures the following interval against the new N. The first pulse after reset or enable arrives after exactly N enabled edges, counted in the same way.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int DEF_A_W   = 5;
  localparam int DEF_B_W   = 12;
  localparam int DEF_BASE  = 64;
  localparam int DEF_EXTRA = 2;
  localparam int DEF_B_MIN = 3;
endpackage

// File: rtl/pswallow_word_reg.sv
module pswallow_word_reg #(
  parameter int A_W   = 5,
  parameter int B_W   = 12,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           load,
  input  logic [A_W+B_W-1:0] word_in,
  input  logic           boundary,
  output logic [A_W-1:0] act_a,
  output logic [B_W-1:0] act_b,
  output logic           word_err
);
  localparam int W = A_W + B_W;
  localparam logic [B_W-1:0] B_LOW = B_W'(B_MIN);

  logic [W-1:0] pend_q;
  logic         pend_v;
  logic [A_W-1:0] in_a;
  logic [B_W-1:0] in_b;
  logic           in_ok;

  assign in_a  = word_in[A_W-1:0];
  assign in_b  = word_in[W-1:A_W];
  assign in_ok = (in_b >= B_LOW) && ({{(B_W-A_W){1'b0}}, in_a} <= in_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      pend_v   <= 1'b0;
      act_a    <= '0;
      act_b    <= B_LOW;
      word_err <= 1'b0;
    end else begin
      if ((boundary || !en) && pend_v) begin
        act_a  <= pend_q[A_W-1:0];
        act_b  <= pend_q[W-1:A_W];
        pend_v <= 1'b0;
      end
      if (load) begin
        word_err <= !in_ok;
        if (in_ok) begin
          pend_q <= word_in;
          pend_v <= 1'b1;
        end
      end
    end
  end

  // R4: the active word only moves at a period boundary or in standby
  p_act_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !boundary) |=> ($stable(act_a) && $stable(act_b)));

  // R5: a rejected word leaves the pending word untouched
  p_reject_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !in_ok) |=> $stable(pend_q));

  // R5: the error flag only changes on a load
  p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word_err));

  // R3: the applied ratio always satisfies the counting rules
  p_act_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (act_b >= B_LOW) && ({{(B_W-A_W){1'b0}}, act_a} <= act_b));
endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
  parameter int BASE  = 64,
  parameter int EXTRA = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ext_mod,
  output logic tc
);
  localparam int PW = $clog2(BASE + EXTRA);
  localparam logic [PW-1:0] LAST_LO = PW'(BASE - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(BASE + EXTRA - 1);

  logic [PW-1:0] pc;
  logic [PW-1:0] last;

  generate
    if (EXTRA > 0) begin : g_dual
      assign last = ext_mod ? LAST_HI : LAST_LO;
    end else begin : g_single
      assign last = LAST_LO;
    end
  endgenerate

  assign tc = (pc == last);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pc <= '0;
    end else if (tc) begin
      pc <= '0;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  // R2: a base-modulus cycle never counts beyond BASE-1
  p_pc_range_r2: assert property (@(posedge clk) disable iff (rst)
    !ext_mod |-> (pc <= LAST_LO));
endmodule

// File: rtl/pswallow_counter.sv
module pswallow_counter #(
  parameter int A_W = 5,
  parameter int B_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           tc,
  input  logic [A_W-1:0] act_a,
  input  logic [B_W-1:0] act_b,
  output logic           ext_mod,
  output logic           period_end
);
  localparam logic [B_W-1:0] ONE_B = B_W'(1);

  logic [B_W-1:0] cnt;

  assign ext_mod    = (cnt < {{(B_W-A_W){1'b0}}, act_a});
  assign period_end = tc && (cnt == act_b - ONE_B);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (tc) begin
      cnt <= period_end ? '0 : cnt + ONE_B;
    end
  end

  // R2: the modulus choice holds for a whole prescaler cycle
  p_mod_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !tc) |=> $stable(ext_mod));

  // R1: the main count stays inside the active period
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt < act_b);
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int A_W   = DEF_A_W,
  parameter int B_W   = DEF_B_W,
  parameter int BASE  = DEF_BASE,
  parameter int EXTRA = DEF_EXTRA,
  parameter int B_MIN = DEF_B_MIN
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 load,
  input  logic [A_W+B_W-1:0]   word,
  output logic                 div_out,
  output logic                 word_err
);
  logic [A_W-1:0] act_a;
  logic [B_W-1:0] act_b;
  logic           ext_mod;
  logic           tc;
  logic           period_end;

  pswallow_word_reg #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_word (
    .clk(clk), .rst(rst), .en(en), .load(load), .word_in(word),
    .boundary(period_end), .act_a(act_a), .act_b(act_b), .word_err(word_err)
  );

  pswallow_prescaler #(.BASE(BASE), .EXTRA(EXTRA)) u_pre (
    .clk(clk), .rst(rst), .en(en), .ext_mod(ext_mod), .tc(tc)
  );

  pswallow_counter #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tc(tc), .act_a(act_a), .act_b(act_b),
    .ext_mod(ext_mod), .period_end(period_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_out <= 1'b0;
    end else begin
      div_out <= en && period_end;
    end
  end

  // R1: the output pulse lasts a single cycle
  p_one_cycle_r1: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  // R6: standby keeps the output low
  p_standby_low_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !div_out);
endmodule

// File: tb/sim_pswallow_div.sv
`timescale 1ns/1ps
module sim_pswallow_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        load = 1'b0;
  logic [16:0] word = '0;
  logic        div_out;
  logic        word_err;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pswallow_div u0 (
    .clk(clk), .rst(rst), .en(en), .load(load), .word(word),
    .div_out(div_out), .word_err(word_err)
  );

  localparam int NV = 6;
  localparam int VA [NV] = '{0, 3, 31, 5, 0, 17};
  localparam int VB [NV] = '{3, 3, 31, 10, 7, 40};

  function automatic int ratio(int a, int b);
    return 2 * (32 * b + a);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; drives a one-cycle load strobe
  task automatic put_word(int a, int b);
    word = {12'(b), 5'(a)};
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // counts rising edges until div_out is seen high at a falling edge
  task automatic measure(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end while (!div_out);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int c;
    int c2;
    int hits;
    repeat (3) @(negedge clk);
    check("R7 div_out in reset", int'(div_out), 0);
    check("R7 word_err in reset", int'(word_err), 0);
    rst = 1'b0;
    en = 1'b1;
    measure(c);
    check("R7 default first pulse", c, 192);
    measure(c);
    check("R1 default period", c, 192);

    // table walk: R1, R2, R3
    for (int i = 0; i < NV; i++) begin
      put_word(VA[i], VB[i]);
      check("R3 accepted word", int'(word_err), 0);
      measure(c);
      measure(c);
      check("R1 R2 period first", c, ratio(VA[i], VB[i]));
      measure(c);
      check("R1 R2 period second", c, ratio(VA[i], VB[i]));
    end

    // R4: mid-period load keeps the running period
    put_word(2, 4);
    measure(c);
    measure(c);
    check("R4 settle", c, ratio(2, 4));
    repeat (10) @(negedge clk);
    put_word(3, 3);
    measure(c2);
    check("R4 old period kept", 11 + c2, ratio(2, 4));
    measure(c);
    check("R4 new period", c, ratio(3, 3));

    // R6 / R8: standby, load during standby
    en = 1'b0;
    hits = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (div_out) hits++;
      if (k == 100) begin
        put_word(2, 5);
        if (div_out) hits++;
      end
    end
    check("R6 output low in standby", hits, 0);
    en = 1'b1;
    measure(c);
    check("R6 R8 first pulse after enable", c, ratio(2, 5));
    measure(c);
    check("R8 period after enable", c, ratio(2, 5));

    // R5: rejected words
    put_word(0, 2);
    check("R5 err on B<3", int'(word_err), 1);
    measure(c);
    measure(c);
    check("R5 ratio kept after B<3", c, ratio(2, 5));
    check("R5 err held", int'(word_err), 1);
    put_word(5, 4);
    check("R5 err on A>B", int'(word_err), 1);
    measure(c);
    measure(c);
    check("R5 ratio kept after A>B", c, ratio(2, 5));
    put_word(4, 4);
    check("R3 err cleared by A=B", int'(word_err), 0);
    measure(c);
    measure(c);
    check("R3 A=B period", c, ratio(4, 4));

    // R7: reset mid-run
    put_word(31, 31);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 div_out after reset", int'(div_out), 0);
    check("R7 word_err after reset", int'(word_err), 0);
    rst = 1'b0;
    measure(c);
    check("R7 default ratio restored", c, 192);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule